// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache Controller

This block sits between a processor's load/store port and a word-wide memory port. It holds 16 KB of data as 256 tagged 64-byte blocks, arranged as 32 sets of 8 ways. Each request is one 32-bit word access. The controller splits the address into fields and compares the tag against every way of the selected set. A hit is served from local storage. A miss allocates a block, for loads and for stores alike.

The replacement policy lives outside this block. On a miss the controller raises a query carrying the set index, and it samples the way number that the replacement logic returns in the same cycle. If that victim is valid and dirty, all of its words go back to memory first. The refill then reads the 16 words of the new block, starting at the requested word and wrapping around. The requester receives its answer as soon as that first word arrives. The cache accepts no new request until the whole block is in place and marked valid.

Stores write only the byte lanes selected by their byte enables. The response to a store returns the resulting word. A constant status output reports the cache geometry.

Top module: `wb_dcache`

## Requirements
- R1: An address splits as byte offset [1:0], word index [5:2], set index [10:6] and tag [31:11]. `geom_info` reads block bytes in [23:16] (64), ways in [15:8] (8) and sets in [7:0] (32).
- R2: A load that hits raises `resp_valid` for exactly one cycle, after the third rising edge counting the edge that accepted the request. `resp_rdata` then carries the stored word.
- R3: A store that hits replaces only the byte lanes whose `req_be` bit is 1 (bit n covers data bits 8n+7:8n). Its response returns the merged word. It causes no memory traffic.
- R4: A refill issues exactly 16 reads (`mem_we`=0). The address of read i is {tag, set, (w+i) mod 16, 2'b00}, where w is the requested word index.
- R5: On a miss, `resp_valid` rises in the cycle right after the first refill read is acknowledged, before any second read completes. `resp_rdata` then carries that word, merged with the store data if the request is a store.
- R6: A block becomes valid only once all 16 refill words have been taken. After that, any word of the block hits with no memory traffic.
- R7: If the chosen victim is valid and dirty, 16 writes (`mem_we`=1) are issued before the first refill read. They go to {victim tag, set, i, 2'b00} for i = 0..15 in order, and carry the victim's current words.
- R8: If the chosen victim is invalid or clean, no memory write is issued for that miss.
- R9: A store miss allocates the block and merges its data into the critical word. It marks the block dirty, so that evicting the block later writes the stored bytes back.
- R10: After reset, `req_ready` is 1 and `resp_valid`, `mem_req` and `vic_query` are 0. Every block is invalid, so the first access misses.
- R11: `vic_query` is high for exactly one cycle per miss, with `vic_set` equal to the set index. It never rises for a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on an edge where both are high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte-lane enables |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Loaded word, or merged word for stores |
| vic_query | output | 1 | Miss: replacement way requested this cycle |
| vic_set | output | 5 | Set index of the query |
| vic_way | input | 3 | Way chosen by the replacement logic |
| mem_req | output | 1 | Memory word transfer pending |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Transfer completes on this edge; read data valid |
| mem_rdata | input | 32 | Refill data |
| geom_info | output | 24 | Constant geometry report |

## Verification
A hit response is due after the third edge counting the accept edge. The bench counts edges from acceptance and requires the strobe at exactly that count, with no memory traffic logged. A miss response is due one cycle after the critical word's acknowledge. The memory model acknowledges at falling edges after random waits, and the bench samples one nanosecond after each rising edge. So when the strobe appears, exactly one refill read must have been logged. The full write-back and refill sequences are then compared word by word against a reference model kept in bench functions.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_HITR,
    ST_WBK,
    ST_FILL
  } dc_state_e;

  localparam int GEOM_FIELD_W = 8;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS  = 32,
  parameter int WAYS  = 8,
  parameter int TAG_W = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  input  logic [$clog2(WAYS)-1:0]  vq_way,
  output logic                     vq_valid,
  output logic                     vq_dirty,
  output logic [TAG_W-1:0]         vq_tag,
  input  logic                     upd_en,
  input  logic [$clog2(WAYS)-1:0]  upd_way,
  input  logic                     upd_valid,
  input  logic                     upd_dirty,
  input  logic                     upd_tag_we,
  input  logic [TAG_W-1:0]         upd_tag
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  vld_q   [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  hv;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hv[g] = vld_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hv[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hv;

  assign vq_valid = vld_q[lk_set][vq_way];
  assign vq_dirty = dirty_q[lk_set][vq_way];
  assign vq_tag   = tag_q[lk_set][vq_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
      end
    end else if (upd_en) begin
      vld_q[lk_set][upd_way]   <= upd_valid;
      dirty_q[lk_set][upd_way] <= upd_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_tag_we) tag_q[lk_set][upd_way] <= upd_tag;
  end

  // R6: a valid tag is never held twice in one set, so at most one way matches
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_idx,
  input  logic [DATA_W/8-1:0]       wr_be,
  input  logic [DATA_W-1:0]         wr_data
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_be[b]) mem_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
  import dc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 8,
  parameter int SETS   = 32,
  parameter int WORDS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  input  logic [DATA_W/8-1:0]          req_be,
  output logic                         resp_valid,
  output logic [DATA_W-1:0]            resp_rdata,
  output logic                         vic_query,
  output logic [$clog2(SETS)-1:0]      vic_set,
  input  logic [$clog2(WAYS)-1:0]      vic_way,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic                         mem_ack,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic [3*GEOM_FIELD_W-1:0]    geom_info
);
  localparam int BYTES     = DATA_W / 8;
  localparam int OFF_W     = $clog2(BYTES);
  localparam int WORD_W    = $clog2(WORDS);
  localparam int SET_W     = $clog2(SETS);
  localparam int WAY_W     = $clog2(WAYS);
  localparam int TAG_W     = ADDR_W - SET_W - WORD_W - OFF_W;
  localparam int LINE_W    = ADDR_W - OFF_W;
  localparam int DEPTH     = SETS * WAYS * WORDS;
  localparam int BLK_BYTES = WORDS * BYTES;
  localparam logic [WORD_W-1:0] CNT_LAST = '1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  dc_state_e           st_q, st_d;
  logic [LINE_W-1:0]   line_q, line_d;
  logic                wr_q, wr_d;
  logic [DATA_W-1:0]   wdat_q, wdat_d;
  logic [BYTES-1:0]    be_q, be_d;
  logic [WAY_W-1:0]    way_q, way_d;
  logic [TAG_W-1:0]    vtag_q, vtag_d;
  logic [WORD_W-1:0]   cnt_q, cnt_d;
  logic                rv_q, rv_d;
  logic [DATA_W-1:0]   rdat_q, rdat_d;

  logic unused_lsb;
  assign unused_lsb = ^req_addr[OFF_W-1:0];

  // address fields of the captured request
  logic [WORD_W-1:0] word_f;
  logic [SET_W-1:0]  set_f;
  logic [TAG_W-1:0]  tag_f;
  assign word_f = line_q[WORD_W-1:0];
  assign set_f  = line_q[WORD_W +: SET_W];
  assign tag_f  = line_q[LINE_W-1 -: TAG_W];

  logic              hit, vq_valid, vq_dirty;
  logic [WAY_W-1:0]  hit_way;
  logic [TAG_W-1:0]  vq_tag;
  logic              upd_en, upd_valid, upd_dirty, upd_tag_we;
  logic [WAY_W-1:0]  upd_way;

  dc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_ni),
    .lk_set     (set_f),
    .lk_tag     (tag_f),
    .hit        (hit),
    .hit_way    (hit_way),
    .vq_way     (vic_way),
    .vq_valid   (vq_valid),
    .vq_dirty   (vq_dirty),
    .vq_tag     (vq_tag),
    .upd_en     (upd_en),
    .upd_way    (upd_way),
    .upd_valid  (upd_valid),
    .upd_dirty  (upd_dirty),
    .upd_tag_we (upd_tag_we),
    .upd_tag    (tag_f)
  );

  logic                      dwr_en;
  logic [WAY_W-1:0]          dwr_way;
  logic [WORD_W-1:0]         dwr_word, rd_word, fill_word;
  logic [BYTES-1:0]          dwr_be;
  logic [DATA_W-1:0]         dwr_data, rd_data, fill_data;

  assign rd_word   = (st_q == ST_WBK) ? cnt_q : word_f;
  assign fill_word = word_f + cnt_q;

  dc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  ({set_f, way_q, rd_word}),
    .rd_data (rd_data),
    .wr_en   (dwr_en),
    .wr_idx  ({set_f, dwr_way, dwr_word}),
    .wr_be   (dwr_be),
    .wr_data (dwr_data)
  );

  function automatic logic [DATA_W-1:0] merge_be(input logic [DATA_W-1:0] base,
                                                  input logic [DATA_W-1:0] nw,
                                                  input logic [BYTES-1:0]  be);
    logic [DATA_W-1:0] r;
    r = base;
    for (int b = 0; b < BYTES; b++) begin
      if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    end
    return r;
  endfunction

  assign fill_data = (cnt_q == '0 && wr_q) ? merge_be(mem_rdata, wdat_q, be_q) : mem_rdata;

  always_comb begin
    st_d   = st_q;
    line_d = line_q;
    wr_d   = wr_q;
    wdat_d = wdat_q;
    be_d   = be_q;
    way_d  = way_q;
    vtag_d = vtag_q;
    cnt_d  = cnt_q;
    rv_d   = 1'b0;
    rdat_d = rdat_q;
    upd_en     = 1'b0;
    upd_way    = way_q;
    upd_valid  = 1'b0;
    upd_dirty  = 1'b0;
    upd_tag_we = 1'b0;
    dwr_en   = 1'b0;
    dwr_way  = way_q;
    dwr_word = fill_word;
    dwr_be   = '1;
    dwr_data = fill_data;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {tag_f, set_f, fill_word, {OFF_W{1'b0}}};
    mem_wdata = rd_data;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          line_d = req_addr[ADDR_W-1:OFF_W];
          wr_d   = req_write;
          wdat_d = req_wdata;
          be_d   = req_be;
          st_d   = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          way_d = hit_way;
          st_d  = ST_HITR;
          if (wr_q) begin
            dwr_en    = 1'b1;
            dwr_way   = hit_way;
            dwr_word  = word_f;
            dwr_be    = be_q;
            dwr_data  = wdat_q;
            upd_en    = 1'b1;
            upd_way   = hit_way;
            upd_valid = 1'b1;
            upd_dirty = 1'b1;
          end
        end else begin
          way_d   = vic_way;
          vtag_d  = vq_tag;
          cnt_d   = '0;
          upd_en  = 1'b1;
          upd_way = vic_way;
          st_d    = (vq_valid && vq_dirty) ? ST_WBK : ST_FILL;
        end
      end
      ST_HITR: begin
        rv_d   = 1'b1;
        rdat_d = rd_data;
        st_d   = ST_IDLE;
      end
      ST_WBK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {vtag_q, set_f, cnt_q, {OFF_W{1'b0}}};
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          dwr_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == '0) begin
            rv_d   = 1'b1;
            rdat_d = fill_data;
          end
          if (cnt_q == CNT_LAST) begin
            upd_en     = 1'b1;
            upd_valid  = 1'b1;
            upd_dirty  = wr_q;
            upd_tag_we = 1'b1;
            st_d       = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    line_q <= line_d;
    wr_q   <= wr_d;
    wdat_q <= wdat_d;
    be_q   <= be_d;
    way_q  <= way_d;
    vtag_q <= vtag_d;
    cnt_q  <= cnt_d;
    rdat_q <= rdat_d;
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign resp_valid = rv_q;
  assign resp_rdata = rdat_q;
  assign vic_query  = (st_q == ST_LOOK) && !hit;
  assign vic_set    = set_f;
  assign geom_info  = {GEOM_FIELD_W'(BLK_BYTES), GEOM_FIELD_W'(WAYS), GEOM_FIELD_W'(SETS)};

  // R2: a hit found in lookup yields the response two edges later
  a_r2_hit_latency: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_LOOK && hit) |=> ##1 resp_valid);

  // R2: the response strobe lasts one cycle
  a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    resp_valid |=> !resp_valid);

  // R4: each non-final refill read is followed by the next word index, modulo the block
  a_r4_wrap_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_we && mem_ack && cnt_q != CNT_LAST) |=>
      (mem_req && !mem_we &&
       mem_addr[OFF_W +: WORD_W] == WORD_W'($past(mem_addr[OFF_W +: WORD_W]) + 1'b1)));

  // R5: the critical word releases the requester on the next cycle
  a_r5_crit_release: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_we && mem_ack && cnt_q == '0) |=> resp_valid);

  // R7: the final write-back word is followed directly by the refill
  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && mem_we && mem_ack && cnt_q == CNT_LAST) |=> (mem_req && !mem_we));

  // R11: the replacement query lasts one cycle
  a_r11_query_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    vic_query |=> !vic_query);
endmodule

// File: tb/wb_dcache_tb.sv
`timescale 1ns/1ps
module wb_dcache_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        vic_query;
  logic [4:0]  vic_set;
  logic [2:0]  vic_way;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [23:0] geom_info;

  wb_dcache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .vic_query(vic_query), .vic_set(vic_set), .vic_way(vic_way),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .geom_info(geom_info)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // backing memory seen by the responder, and the model's own copy
  logic [31:0] bmem [int unsigned];
  logic [31:0] smem [int unsigned];
  function automatic logic [31:0] initv(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A17_C3E1;
  endfunction
  function automatic logic [31:0] brd(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : initv(a);
  endfunction
  function automatic logic [31:0] srd(input logic [31:0] a);
    return smem.exists(a) ? smem[a] : initv(a);
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] b, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = b;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction
  function automatic logic [31:0] mk(input int tag, input int set, input int word);
    return {21'(tag), 5'(set), 4'(word), 2'b00};
  endfunction

  typedef struct { bit we; logic [31:0] a; logic [31:0] d; } tx_t;
  tx_t log_q[$];
  int  wait_c = 0;

  // memory responder: grants at falling edges, consumed at the next rising edge
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wait_c == 0) begin
        tx_t t;
        t.we = mem_we; t.a = mem_addr; t.d = mem_wdata;
        log_q.push_back(t);
        if (mem_we) bmem[mem_addr] = mem_wdata;
        else        mem_rdata = brd(mem_addr);
        mem_ack = 1'b1;
        wait_c = $urandom % 3;
      end else begin
        wait_c--;
      end
    end
  end

  // reference model state
  bit          m_v [32][8];
  bit          m_d [32][8];
  logic [20:0] m_t [32][8];
  logic [31:0] m_dat [32][8][16];

  task automatic op(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                    input logic [3:0] be, input logic [2:0] vw);
    int set = int'(addr[10:6]);
    int word = int'(addr[5:2]);
    logic [20:0] tag = addr[31:11];
    bit hit = 0;
    int hw = 0;
    int c, reads, extra_q, guard;
    bit got;
    logic [31:0] rdata, exp;
    tx_t exp_q[$];
    for (int w = 0; w < 8; w++) if (m_v[set][w] && m_t[set][w] == tag) begin hit = 1; hw = w; end

    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be; vic_way = vw;
    log_q.delete();
    @(posedge clk); #1;
    req_valid = 0;
    c = 1;
    chk(vic_query == !hit, "R11 query on miss only", 32'(vic_query), 32'(!hit));
    if (!hit) chk(vic_set == 5'(set), "R11 query set", 32'(vic_set), 32'(set));
    got = 0; reads = 0; extra_q = 0; guard = 0; rdata = '0;
    while (!got && guard < 3000) begin
      @(posedge clk); #1; c++; guard++;
      if (vic_query) extra_q++;
      if (resp_valid) begin
        got = 1; rdata = resp_rdata;
        foreach (log_q[i]) if (!log_q[i].we) reads++;
      end
    end
    while (!req_ready && guard < 3000) begin
      @(posedge clk); #1; guard++;
      if (vic_query) extra_q++;
      if (resp_valid) extra_q += 100;
    end
    chk(got, "R2/R5 response seen", 32'(got), 32'd1);
    chk(extra_q == 0, "R11/R2 single query and single response", 32'(extra_q), 32'd0);

    if (hit) begin
      chk(c == 3, "R2 hit latency in edges", 32'(c), 32'd3);
      chk(log_q.size() == 0, "R6 hit makes no memory traffic", 32'(log_q.size()), 32'd0);
      if (wr) begin
        m_dat[set][hw][word] = merge(m_dat[set][hw][word], wd, be);
        m_d[set][hw] = 1;
      end
      exp = m_dat[set][hw][word];
      chk(rdata == exp, wr ? "R3 store hit merged word" : "R2 hit load data", rdata, exp);
    end else begin
      if (m_v[set][vw] && m_d[set][vw]) begin
        for (int i = 0; i < 16; i++) begin
          tx_t t;
          t.we = 1; t.a = mk(int'(m_t[set][vw]), set, i); t.d = m_dat[set][vw][i];
          exp_q.push_back(t);
          smem[t.a] = t.d;
        end
      end
      for (int i = 0; i < 16; i++) begin
        tx_t t;
        int wi = (word + i) % 16;
        t.we = 0; t.a = mk(int'(tag), set, wi); t.d = '0;
        exp_q.push_back(t);
        m_dat[set][vw][wi] = srd(t.a);
      end
      if (wr) m_dat[set][vw][word] = merge(m_dat[set][vw][word], wd, be);
      m_v[set][vw] = 1; m_d[set][vw] = wr; m_t[set][vw] = tag;
      chk(reads == 1, "R5 response after critical word only", 32'(reads), 32'd1);
      chk(log_q.size() == exp_q.size(), exp_q.size() > 16 ? "R7 transfer count" : "R8 transfer count",
          32'(log_q.size()), 32'(exp_q.size()));
      if (log_q.size() == exp_q.size()) begin
        int bad = -1;
        for (int i = 0; i < exp_q.size(); i++) begin
          if (bad < 0 && (log_q[i].we != exp_q[i].we || log_q[i].a != exp_q[i].a ||
                          (exp_q[i].we && log_q[i].d != exp_q[i].d))) bad = i;
        end
        if (bad >= 0)
          chk(0, exp_q[bad].we ? "R7 write-back address/data" : "R4 refill order",
              log_q[bad].we ? log_q[bad].d ^ log_q[bad].a : log_q[bad].a,
              exp_q[bad].we ? exp_q[bad].d ^ exp_q[bad].a : exp_q[bad].a);
        else
          chk(1, "R4 refill order", 0, 0);
      end
      exp = m_dat[set][vw][word];
      chk(rdata == exp, wr ? "R9 store miss merged word" : "R5 critical word data", rdata, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    vic_way = '0; mem_ack = 0; mem_rdata = '0;
    for (int s = 0; s < 32; s++) for (int w = 0; w < 8; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; end
    #12.3 rst_n = 1;
    repeat (4) @(posedge clk); #1;
    // R10 reset state, R1 geometry
    chk(req_ready == 1, "R10 ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 0, "R10 no response after reset", 32'(resp_valid), 32'd0);
    chk(mem_req == 0, "R10 no memory request after reset", 32'(mem_req), 32'd0);
    chk(vic_query == 0, "R10 no query after reset", 32'(vic_query), 32'd0);
    chk(geom_info == 24'h40_08_20, "R1 geometry report", 32'(geom_info), 32'h0040_0820);

    // directed corner cases, all in set 2
    op(0, mk(3, 2, 5), 0, 4'h0, 3'd1);              // R10 first access misses, R4 wrap from 5
    op(0, mk(3, 2, 12), 0, 4'h0, 3'd6);             // R6 rest of block hits
    op(1, mk(3, 2, 12), 32'hDEAD_BEEF, 4'b0101, 3'd0); // R3 partial store hit
    op(0, mk(3, 2, 12), 0, 4'h0, 3'd0);             // R3 merged word read back
    op(1, mk(7, 2, 15), 32'h1234_5678, 4'b1111, 3'd2); // R9 store miss, R4 wrap from 15
    op(0, mk(9, 2, 0), 0, 4'h0, 3'd1);              // R7 dirty victim write-back
    op(0, mk(7, 2, 3), 0, 4'h0, 3'd4);              // R6 hit on allocated block
    op(0, mk(3, 2, 12), 0, 4'h0, 3'd2);             // R9 stored data leaves by write-back, returns by refill
    op(0, mk(5, 2, 0), 0, 4'h0, 3'd4);              // R8 empty victim
    op(0, mk(6, 2, 7), 0, 4'h0, 3'd4);              // R8 clean victim, no writes

    // constrained random mix over few tags and sets to force evictions
    for (int n = 0; n < 400; n++) begin
      bit wr = ($urandom % 5) < 2;
      op(wr, mk($urandom % 10, $urandom % 4, $urandom % 16), $urandom,
         4'(($urandom % 15) + 1), 3'($urandom % 8));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule